// File: doc/BRIEF.md
# A/D Scan Channel Sequencer

This block decides which analog channel is converted next and when. A trigger starts the work. It comes either from a software start strobe or from a pulse of a sampling clock, and a mode input picks which of the two is used. The channel range is held as a low bound and a high bound, which are loaded through a range write strobe.

In scan mode, one trigger converts every channel from the low bound up to the high bound, in ascending order. In single mode, one trigger converts only the channel at the pointer. The pointer then steps forward and waits for the next trigger.

The converter is reached through a start/done handshake. The block gives a one-cycle start pulse together with a channel number. It then waits for a done pulse that carries the 16-bit result, and passes each result to a FIFO write port one cycle later. A busy flag covers the whole of the work done for one trigger.

Top module: `adc_scan_seq`

## Requirements
- R1: With `scan_en` high when a trigger is accepted, the block converts every channel from the low bound to the effective high bound, in ascending order, one conversion each, and then goes idle.
- R2: With `scan_en` low, a trigger converts only the channel at the pointer. The pointer then moves to the next channel. From the effective high bound (or any channel above it) it wraps to the low bound.
- R3: `busy` rises on the clock edge that accepts a trigger. It stays high until the edge that takes the last `conv_done` of that trigger, and it is low at all other times. `conv_start` is only ever high while `busy` is high.
- R4: With `clk_trig_en` low, only `sw_start` starts work. With `clk_trig_en` high, only `trig_clk` starts work. The other input has no effect.
- R5: Each `conv_done` taken while busy gives exactly one `fifo_wr` pulse on the next cycle, with `fifo_data` equal to the `conv_data` that came with that done.
- R6: A trigger that arrives while `busy` is high is ignored: no extra conversion is started and no extra sample is written.
- R7: When the low bound is greater than the high bound, the effective high bound is the low bound, so the range is that one channel, in both modes.
- R8: A pulse on `range_wr` loads `range_lo`/`range_hi` as the new bounds and sets the pointer to `range_lo`. If it comes in the same cycle as the pointer step at the end of a single-mode conversion, the reload wins.
- R9: After reset: `busy`, `conv_start` and `fifo_wr` are low, and both bounds and the pointer are channel 0.
- R10: Each scan begins at the low bound, wherever the single-mode pointer was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | 1: convert the whole range per trigger; 0: convert one channel per trigger |
| clk_trig_en | input | 1 | 1: trigger from `trig_clk`; 0: trigger from `sw_start` |
| sw_start | input | 1 | Software start strobe |
| trig_clk | input | 1 | Sampling clock pulse (one cycle wide) |
| range_wr | input | 1 | Load new bounds and reset the pointer |
| range_lo | input | CH_W | Low bound to load |
| range_hi | input | CH_W | High bound to load |
| busy | output | 1 | Work for the current trigger is in progress |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CH_W | Channel being converted |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | DATA_W | Result that comes with `conv_done` |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | Sample to write |

## Verification
Two updates can meet in one cycle: a range write, and the pointer step that ends a single-mode conversion. The bench's converter model raises `range_wr` on the same edge as its `conv_done`. The next single-mode trigger must then convert the newly loaded low bound, not the channel after the old pointer. A second coincidence is a start strobe given while a scan is running. For this one, the scoreboard must see the exact channel list of the first trigger and nothing more.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              clk_trig_en,
  input  logic              sw_start,
  input  logic              trig_clk,
  input  logic              range_wr,
  input  logic [CH_W-1:0]   range_lo,
  input  logic [CH_W-1:0]   range_hi,
  output logic              busy,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data
);

  logic              busy_q, start_q, wr_q, scan_q;
  logic [CH_W-1:0]   lo_q, hi_q, ptr_q, chan_q;
  logic [DATA_W-1:0] data_q;

  wire            trig    = clk_trig_en ? trig_clk : sw_start;
  wire [CH_W-1:0] top     = (lo_q > hi_q) ? lo_q : hi_q;
  wire            last    = (chan_q >= top);
  wire [CH_W-1:0] chan_nx = last ? lo_q : chan_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      wr_q    <= 1'b0;
      scan_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      ptr_q   <= '0;
      chan_q  <= '0;
      data_q  <= '0;
    end else begin
      start_q <= 1'b0;
      wr_q    <= 1'b0;
      if (!busy_q) begin
        if (trig) begin
          busy_q  <= 1'b1;
          start_q <= 1'b1;
          scan_q  <= scan_en;
          chan_q  <= scan_en ? lo_q : ptr_q;
        end
      end else if (conv_done) begin
        wr_q   <= 1'b1;
        data_q <= conv_data;
        if (scan_q && !last) begin
          chan_q  <= chan_nx;
          start_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
          if (!scan_q) ptr_q <= chan_nx;
        end
      end
      if (range_wr) begin
        lo_q  <= range_lo;
        hi_q  <= range_hi;
        ptr_q <= range_lo;
      end
    end
  end

  assign busy       = busy_q;
  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign fifo_wr    = wr_q;
  assign fifo_data  = data_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_data,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic              range_wr,
  input logic [CH_W-1:0]   range_lo,
  input logic [CH_W-1:0]   lo,
  input logic [CH_W-1:0]   hi,
  input logic [CH_W-1:0]   ptr
);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(conv_done)) |-> !conv_start);

  assert_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy) |=> (fifo_wr && fifo_data == $past(conv_data)));

  assert_push_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(conv_done));

  assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !$past(range_wr)) |->
      (conv_chan >= lo && conv_chan <= ((lo > hi) ? lo : hi)));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    range_wr |=> (ptr == $past(range_lo)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .conv_start(conv_start),
  .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
  .fifo_wr(fifo_wr), .fifo_data(fifo_data), .range_wr(range_wr),
  .range_lo(range_lo), .lo(lo_q), .hi(hi_q), .ptr(ptr_q)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int CH_W = 4;
  localparam int DW   = 16;
  localparam int LAT  = 3;

  logic clk = 0, rst_n = 0;
  logic scan_en = 0, clk_trig_en = 0, sw_start = 0, trig_clk = 0;
  logic rw_task = 0, rw_conv = 0;
  logic [CH_W-1:0] in_lo = 0, in_hi = 0;
  logic busy, conv_start, conv_done = 0, fifo_wr;
  logic [CH_W-1:0] conv_chan;
  logic [DW-1:0] conv_data = 0, fifo_data;
  wire range_wr = rw_task | rw_conv;

  int checks = 0, errors = 0;
  bit collide = 0, finished = 0;
  logic [CH_W-1:0] expq[$];
  logic [CH_W-1:0] mlo = 0, mhi = 0, mptr = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.CH_W(CH_W), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .clk_trig_en(clk_trig_en),
    .sw_start(sw_start), .trig_clk(trig_clk), .range_wr(range_wr),
    .range_lo(in_lo), .range_hi(in_hi), .busy(busy), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data));

  function automatic logic [DW-1:0] pat(input logic [CH_W-1:0] c);
    return {c, ~c, c, ~c};
  endfunction

  function automatic logic [CH_W-1:0] mtop();
    return (mlo > mhi) ? mlo : mhi;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model; may raise a range write on the same edge as done (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        logic [CH_W-1:0] ch;
        ch = conv_chan;
        repeat (LAT) @(negedge clk);
        conv_done = 1;
        conv_data = pat(ch);
        if (collide) rw_conv = 1;
        @(posedge clk);
        #1;
        conv_done = 0;
        rw_conv = 0;
        collide = 0;
      end
    end
  end

  // scoreboard monitor (R5)
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      if (expq.size() == 0) begin
        chk(0, "R5 unexpected sample", int'(fifo_data), -1);
      end else begin
        logic [CH_W-1:0] e;
        e = expq.pop_front();
        chk(fifo_data == pat(e), "R1/R2/R5 sample", int'(fifo_data), int'(pat(e)));
      end
    end
  end

  task automatic set_range(input logic [CH_W-1:0] lo, input logic [CH_W-1:0] hi);
    @(negedge clk);
    in_lo = lo; in_hi = hi; rw_task = 1;
    @(negedge clk);
    rw_task = 0;
    mlo = lo; mhi = hi; mptr = lo;
  endtask

  task automatic fire(input bit scan, input bit retrig, input string req);
    scan_en = scan;
    if (scan) begin
      for (int c = int'(mlo); c <= int'(mtop()); c++) expq.push_back(CH_W'(c));
    end else begin
      expq.push_back(mptr);
      if (collide) mptr = in_lo;
      else mptr = (mptr >= mtop()) ? mlo : mptr + 1'b1;
      if (collide) begin mlo = in_lo; mhi = in_hi; end
    end
    @(negedge clk);
    if (clk_trig_en) trig_clk = 1; else sw_start = 1;
    @(negedge clk);
    trig_clk = 0; sw_start = 0;
    chk(busy == 1, {"R3 busy after trigger ", req}, busy, 1);
    if (retrig) begin
      @(negedge clk);
      if (clk_trig_en) trig_clk = 1; else sw_start = 1;
      @(negedge clk);
      trig_clk = 0; sw_start = 0;
    end
    while (busy) @(negedge clk);
    repeat (LAT + 3) @(negedge clk);
    chk(busy == 0, {"R3 idle after work ", req}, busy, 0);
    chk(expq.size() == 0, {"sample count ", req}, expq.size(), 0);
  endtask

  task automatic stray(input bit use_clk, input string req);
    @(negedge clk);
    if (use_clk) trig_clk = 1; else sw_start = 1;
    @(negedge clk);
    trig_clk = 0; sw_start = 0;
    repeat (LAT + 3) begin
      chk(busy == 0 && conv_start == 0, req, busy, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && conv_start == 0 && fifo_wr == 0, "R9 reset outputs", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && fifo_wr == 0, "R9 idle after reset", busy, 0);
    fire(0, 0, "R9 default channel 0");
    fire(1, 0, "R9 default scan of 0");

    set_range(2, 5);
    for (int i = 0; i < 5; i++) fire(0, 0, "R2 step and wrap");
    fire(1, 1, "R1 R6 scan with retrigger");
    fire(0, 0, "R2 pointer kept after scan");
    fire(1, 0, "R10 scan restarts at low bound");
    fire(0, 1, "R6 single with retrigger");

    stray(1, "R4 trig_clk ignored in software mode");
    clk_trig_en = 1;
    stray(0, "R4 sw_start ignored in clock mode");
    fire(1, 0, "R4 clock-triggered scan");
    fire(0, 0, "R4 clock-triggered single");
    clk_trig_en = 0;

    set_range(7, 3);
    fire(1, 0, "R7 inverted range scan");
    fire(0, 0, "R7 inverted range single a");
    fire(0, 0, "R7 inverted range single b");

    set_range(13, 15);
    fire(0, 0, "R2 single 13");
    set_range(9, 12);
    fire(0, 0, "R8 reload to low bound");
    in_lo = 4; in_hi = 6; collide = 1;
    fire(0, 0, "R8 collision single");
    fire(0, 0, "R8 reload wins over step");
    fire(1, 0, "R8 new range scan");

    set_range(13, 15);
    fire(1, 0, "R1 top-of-range scan");
    for (int i = 0; i < 4; i++) fire(0, 0, "R2 wrap at top channel");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule